// File: doc/BRIEF.md
# Configurable Leading/Trailing Digit Scanner and Magnitude Comparator

This block finds the position of the most significant (or, on request, least significant) set bit of a `2**H`-bit vector, or, after complementing the vector, the position of such a clear bit. Its second use is to compare two unsigned `2**(H-1)`-bit operands that arrive interleaved in the same vector. Both functions share one binary tree of `H` combinational stages. Only the 2-bit leaf cells depend on the mode. Each tree node selects between its two subtrees and reports whether anything was found below it.

Three controls steer the tree. A mode select turns the leaves from an OR (digit scan) into an XOR of an operand pair (compare). An invert control complements every input bit before use, so clear bits are found instead of set bits. A flip control turns the priority around at every node, so the lowest qualifying position wins instead of the highest. The result is an `H`-bit position, counted from bit 0 at the LSB, plus a found flag. Both are registered once at the block's output.

Top module: `digit_scan_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next values of `found_q` and `pos_q` are 0, whatever the other inputs are.
- R2: Outputs change only at a rising clock edge. The values seen after an edge are computed from the inputs sampled at that edge (one cycle of latency). Input changes between edges do not reach the outputs.
- R3: With `cmp_mode`=0, `inv_en`=0 and `flip_en`=0, `found_q` is the OR of all bits of `vec_in`. When it is 1, `pos_q` is the index of the highest set bit.
- R4: With `inv_en`=1, every bit of `vec_in` is complemented before use in either mode. In scan mode this reports the clear bits: the highest clear bit, or the lowest clear bit when `flip_en`=1.
- R5: With `cmp_mode`=0 and `flip_en`=1, `pos_q` is the index of the lowest qualifying bit.
- R6: With `cmp_mode`=1, operand A bit i is `vec_in[2i+1]` and operand B bit i is `vec_in[2i]`. `found_q` is 0 exactly when A equals B (after any inversion). When `flip_en`=0 and `found_q`=1, `pos_q[H-1:1]` is the index of the most significant pair that differs. `pos_q[0]` is that pair's A bit, so with `inv_en`=0 it is 1 exactly when A > B (unsigned).
- R7: With `cmp_mode`=1 and `flip_en`=1, `pos_q[H-1:1]` is the index of the least significant differing pair, and `pos_q[0]` is that pair's A bit.
- R8: With `cmp_mode`=1 and `inv_en`=1, both operands are complemented before the pair decision, so `pos_q[0]` holds the complemented A bit of the chosen pair.
- R9: When `found_q` is 0 the value of `pos_q` carries no meaning (outside reset) and may hold any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_mode | input | 1 | 1: compare interleaved operands; 0: digit scan |
| inv_en | input | 1 | Complement every input bit before use |
| flip_en | input | 1 | Lowest qualifying position wins |
| vec_in | input | 2**H | Vector to scan, or interleaved A/B operands |
| pos_q | output | H | Registered position of the winning bit or pair |
| found_q | output | 1 | Registered flag: a qualifying bit or differing pair exists |

## Verification
The only state is the output register, so a fault inside the tree appears at the ports one cycle after any vector that routes through the faulty leaf or node. A wrong node select shows as a position bit taken from the wrong subtree. A flip mux wired to the wrong half shows up only when both halves hold a candidate. An invert or mode fault at a leaf changes `found_q` for vectors whose set bits appear only in that pair. For this reason the small width is driven through every vector under all control combinations, and the wide width is driven with random vectors and with edge positions at both ends.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

  typedef struct packed {
    logic cmp;
    logic inv;
    logic flip;
  } scan_ctrl_t;

  typedef struct packed {
    logic e;
    logic p;
  } leaf_res_t;

  // Two-bit cell: hi/lo are one pair of the input vector.
  function automatic leaf_res_t leaf_eval(logic hi, logic lo, scan_ctrl_t c);
    leaf_res_t r;
    logic a, b;
    a = hi ^ c.inv;
    b = lo ^ c.inv;
    r.e = c.cmp ? (a ^ b) : (a | b);
    r.p = c.flip ? ~b : a;
    return r;
  endfunction

endpackage

// File: rtl/dsu_leaf.sv
module dsu_leaf
  import dsu_pkg::*;
(
  input  logic       bit_hi,
  input  logic       bit_lo,
  input  scan_ctrl_t ctrl,
  output logic       e_out,
  output logic       p_out
);

  leaf_res_t res;

  always_comb begin
    res   = leaf_eval(bit_hi, bit_lo, ctrl);
    e_out = res.e;
    p_out = res.p;
  end

endmodule

// File: rtl/dsu_node.sv
module dsu_node #(
  parameter int W = 1
) (
  input  logic         flip,
  input  logic         e_hi,
  input  logic         e_lo,
  input  logic [W-1:0] p_hi,
  input  logic [W-1:0] p_lo,
  output logic         e_out,
  output logic [W:0]   p_out
);

  logic take_hi;

  always_comb begin
    // Priority mux: normal order favours the upper half, flipped order the lower.
    take_hi = flip ? ~e_lo : e_hi;
    e_out   = e_hi | e_lo;
    p_out   = {take_hi, (take_hi ? p_hi : p_lo)};
  end

endmodule

// File: rtl/digit_scan_unit.sv
module digit_scan_unit
  import dsu_pkg::*;
#(
  parameter int H = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_mode,
  input  logic             inv_en,
  input  logic             flip_en,
  input  logic [2**H-1:0]  vec_in,
  output logic [H-1:0]     pos_q,
  output logic             found_q
);

  localparam int N      = 2**H;
  localparam int NLEAF  = N / 2;

  scan_ctrl_t ctrl;
  assign ctrl = '{cmp: cmp_mode, inv: inv_en, flip: flip_en};

  for (genvar l = 0; l < H; l++) begin : g_lvl
    localparam int NN = NLEAF >> l;
    logic       e_v [NN];
    logic [l:0] p_v [NN];

    if (l == 0) begin : g_leaf
      for (genvar n = 0; n < NN; n++) begin : g_cell
        dsu_leaf i_leaf (
          .bit_hi (vec_in[2*n+1]),
          .bit_lo (vec_in[2*n]),
          .ctrl   (ctrl),
          .e_out  (e_v[n]),
          .p_out  (p_v[n][0])
        );
      end
    end else begin : g_tree
      for (genvar n = 0; n < NN; n++) begin : g_cell
        dsu_node #(.W(l)) i_node (
          .flip  (flip_en),
          .e_hi  (g_lvl[l-1].e_v[2*n+1]),
          .e_lo  (g_lvl[l-1].e_v[2*n]),
          .p_hi  (g_lvl[l-1].p_v[2*n+1]),
          .p_lo  (g_lvl[l-1].p_v[2*n]),
          .e_out (e_v[n]),
          .p_out (p_v[n])
        );
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      found_q <= 1'b0;
    end else begin
      pos_q   <= g_lvl[H-1].p_v[0];
      found_q <= g_lvl[H-1].e_v[0];
    end
  end

endmodule

// File: rtl/dsu_checker.sv
module dsu_checker #(
  parameter int H = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            cmp_mode,
  input logic            inv_en,
  input logic            flip_en,
  input logic [2**H-1:0] vec_in,
  input logic [H-1:0]    pos_q,
  input logic            found_q
);

  localparam int N  = 2**H;
  localparam int NP = N / 2;
  localparam logic [N-1:0] ONE_N = 1;

  logic [N-1:0]  xv;
  logic [NP-1:0] a_v, b_v;

  always_comb begin
    xv = vec_in ^ {N{inv_en}};
    for (int i = 0; i < NP; i++) begin
      a_v[i] = xv[2*i+1];
      b_v[i] = xv[2*i];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (found_q == 1'b0 && pos_q == '0)); // R1

  AST_SCAN_HIGHEST: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && !flip_en) |=> (!found_q || (($past(xv) >> pos_q) == ONE_N))); // R3

  AST_SCAN_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && flip_en) |=> (!found_q ||
      (((($past(xv) >> pos_q) & ONE_N) == ONE_N) &&
       (($past(xv) & ((ONE_N << pos_q) - ONE_N)) == '0)))); // R5

  AST_SCAN_FOUND: assert property (@(posedge clk) disable iff (rst)
    !cmp_mode |=> (found_q == ($past(xv) != '0))); // R4

  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (rst)
    cmp_mode |=> (found_q == ($past(a_v) != $past(b_v)))); // R6

  AST_CMP_GREATER: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && !flip_en) |=> (!found_q || (pos_q[0] == ($past(a_v) > $past(b_v))))); // R6

endmodule

bind digit_scan_unit dsu_checker #(.H(H)) i_dsu_checker (
  .clk      (clk),
  .rst      (rst),
  .cmp_mode (cmp_mode),
  .inv_en   (inv_en),
  .flip_en  (flip_en),
  .vec_in   (vec_in),
  .pos_q    (pos_q),
  .found_q  (found_q)
);

// File: tb/test_digit_scan_unit.sv
module test_digit_scan_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp = 1'b0, inv = 1'b0, flip = 1'b0;
  logic [31:0] vec5 = '0;
  logic [7:0]  vec3 = '0;
  logic [4:0]  pos5;
  logic [2:0]  pos3;
  logic        fnd5, fnd3;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  digit_scan_unit #(.H(5)) i_digit_scan_unit (
    .clk(clk), .rst(rst), .cmp_mode(cmp), .inv_en(inv), .flip_en(flip),
    .vec_in(vec5), .pos_q(pos5), .found_q(fnd5));

  digit_scan_unit #(.H(3)) i_digit_scan_unit_h3 (
    .clk(clk), .rst(rst), .cmp_mode(cmp), .inv_en(inv), .flip_en(flip),
    .vec_in(vec3), .pos_q(pos3), .found_q(fnd3));

  // Loop-based reference: returns {found, pos}.
  function automatic logic [5:0] ref_scan(int n, logic [31:0] v, logic c, logic iv, logic fl);
    logic [31:0] x;
    logic        f;
    int          p;
    x = v ^ (iv ? 32'hFFFF_FFFF : 32'h0);
    f = 1'b0;
    p = 0;
    if (!c) begin
      for (int k = 0; k < n; k++) begin
        int i;
        i = fl ? (n - 1 - k) : k;
        if (x[i]) begin f = 1'b1; p = i; end
      end
    end else begin
      for (int k = 0; k < n/2; k++) begin
        int j;
        j = fl ? (n/2 - 1 - k) : k;
        if (x[2*j+1] != x[2*j]) begin f = 1'b1; p = 2*j + (x[2*j+1] ? 1 : 0); end
      end
    end
    return {f, p[4:0]};
  endfunction

  function automatic string tag_of(logic c, logic iv, logic fl);
    if (c) return fl ? "R7" : (iv ? "R8" : "R6");
    return fl ? "R5" : (iv ? "R4" : "R3");
  endfunction

  function automatic logic [31:0] weave(logic [15:0] a, logic [15:0] b);
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin
      r[2*i+1] = a[i];
      r[2*i]   = b[i];
    end
    return r;
  endfunction

  // Position compared only where the flag says it is meaningful (R9).
  task automatic chk(string tag, string what, logic gf, logic [4:0] gp, logic [5:0] e);
    n_run++;
    if (gf !== e[5] || (e[5] && gp !== e[4:0])) begin
      n_fail++;
      $display("FAIL %s %s: got found=%0d pos=%0d, expected found=%0d pos=%0d",
               tag, what, gf, gp, e[5], e[4:0]);
    end
  endtask

  task automatic step(logic [31:0] v5, logic [7:0] v3, logic c, logic iv, logic fl);
    @(negedge clk);
    vec5 = v5; vec3 = v3; cmp = c; inv = iv; flip = fl;
    @(negedge clk);
    chk(tag_of(c, iv, fl), "wide", fnd5, pos5, ref_scan(32, v5, c, iv, fl));
    chk(tag_of(c, iv, fl), "narrow", fnd3, {2'b00, pos3}, ref_scan(8, {24'h0, v3}, c, iv, fl));
  endtask

  task automatic test_reset();
    vec5 = 32'hFFFF_FFFF; vec3 = 8'hFF; cmp = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset wide", fnd5, pos5, 6'b0_00000);
    chk("R1", "reset pos wide", 1'b1, pos5, 6'b1_00000);
    chk("R1", "reset narrow", fnd3, {2'b00, pos3}, 6'b0_00000);
    rst = 1'b0;
    step(32'h0000_0100, 8'h04, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "mid-run reset", fnd5, pos5, 6'b0_00000);
    rst = 1'b0;
  endtask

  task automatic test_latency();
    step(32'h0000_0010, 8'h10, 1'b0, 1'b0, 1'b0);
    vec5 = 32'h4000_0000; vec3 = 8'h01;
    #1;
    chk("R2", "hold between edges", fnd5, pos5, 6'b1_00100);
    chk("R2", "hold narrow", fnd3, {2'b00, pos3}, 6'b1_00100);
    @(negedge clk);
    chk("R2", "update after edge", fnd5, pos5, 6'b1_11110);
    chk("R2", "update narrow", fnd3, {2'b00, pos3}, 6'b1_00000);
  endtask

  task automatic test_scan_edges();
    step(32'h0, 8'h0, 1'b0, 1'b0, 1'b0);
    chk("R3", "all zero", fnd5, pos5, 6'b0_00000);
    step(32'h8000_0001, 8'h81, 1'b0, 1'b0, 1'b0);
    chk("R3", "msb wins", fnd5, pos5, {1'b1, 5'd31});
    step(32'h8000_0001, 8'h81, 1'b0, 1'b0, 1'b1);
    chk("R5", "lsb wins flipped", fnd5, pos5, {1'b1, 5'd0});
    step(32'hFFFF_FFFF, 8'hFF, 1'b0, 1'b1, 1'b0);
    chk("R4", "no clear bit", fnd5, pos5, 6'b0_00000);
    step(32'h7FFF_FFFF, 8'h7F, 1'b0, 1'b1, 1'b0);
    chk("R4", "leading zero at top", fnd5, pos5, {1'b1, 5'd31});
    step(32'h0000_FFFF, 8'h0F, 1'b0, 1'b1, 1'b1);
    chk("R4", "trailing zero", fnd5, pos5, {1'b1, 5'd16});
  endtask

  task automatic test_compare();
    step(weave(16'd5, 16'd3), 8'h0, 1'b1, 1'b0, 1'b0);
    chk("R6", "A>B", fnd5, pos5, {1'b1, 5'd5});
    step(weave(16'd3, 16'd5), 8'h0, 1'b1, 1'b0, 1'b0);
    chk("R6", "A<B", fnd5, pos5, {1'b1, 5'd4});
    step(weave(16'hBEEF, 16'hBEEF), 8'h0, 1'b1, 1'b0, 1'b0);
    chk("R6", "A==B", fnd5, pos5, 6'b0_00000);
    step(weave(16'd5, 16'd3), 8'h0, 1'b1, 1'b0, 1'b1);
    chk("R7", "lowest differing pair", fnd5, pos5, {1'b1, 5'd2});
    step(weave(16'd5, 16'd3), 8'h0, 1'b1, 1'b1, 1'b0);
    chk("R8", "inverted operands", fnd5, pos5, {1'b1, 5'd4});
  endtask

  task automatic test_exhaustive_narrow();
    for (int cv = 0; cv < 8; cv++) begin
      for (int v = 0; v < 256; v++) begin
        step($urandom, v[7:0], cv[2], cv[1], cv[0]);
      end
    end
  endtask

  task automatic test_random_wide();
    for (int k = 0; k < 800; k++) begin
      logic [31:0] v;
      v = $urandom;
      if (k % 4 == 1) v = v & ($urandom >> (k % 31));
      if (k % 4 == 2) v = v | (32'hFFFF_FFFF << (k % 32));
      step(v, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    test_reset();
    test_latency();
    test_scan_edges();
    test_compare();
    test_exhaustive_narrow();
    test_random_wide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule